// File: doc/BRIEF.md
# Serial ADC Read Controller

This block sits on the host side of a three-wire serial analog-to-digital converter that returns up to 16 result bits. It runs from a fast system clock. It makes the converter's data clock from a programmable half-period divider, drives an active-low chip select, and samples the converter's serial output. The converter changes its output on falling data-clock edges. The controller captures on the rising edges that follow.

Each frame opens by lowering chip select with the data clock low. The controller then lets five clock periods pass for the sampling window and reads one null bit, which must be low. After that it collects the chosen number of leading result bits, most significant first, and fills the unread low bits with zeros. Chip select is released as the clock falls after the last needed bit, so the converter can power down completely. At that same moment a one-cycle strobe presents the assembled word, the count of valid bits and a flag that reports a bad null bit.

A frame can be started by a single pulse. Free-run mode instead repeats frames at a programmed sample period, counted in data-clock periods, and chip select stays high for at least one data-clock period between frames.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, csN is 1, sclk is 0, resValid is 0, resData is 0, resBits is 0 and nullErr is 0.
- R2: The data clock is 0 whenever csN is 1. While csN is 0, every low phase and every high phase of sclk lasts exactly halfDiv system cycles, and a halfDiv of 0 is treated as 1. The first low phase counts from the cycle in which csN falls.
- R3: A frame holds csN at 0 for exactly 2*H*(6+n) system cycles and produces exactly 6+n rising sclk edges, where H is the effective half period and n is the effective bit count. csN returns to 1 in the same cycle that sclk falls after rising edge 6+n.
- R4: The sdIn values sampled at rising edges 7 to 6+n form the result, with the value at edge 7 in bit 15 and each later edge one position lower. Bits below the n captured bits are 0. The sdIn values at rising edges 1 to 5 do not affect the result.
- R5: sdIn is sampled at rising edge 6 as the null bit. nullErr is 1 with the result when that sample was 1, and 0 otherwise.
- R6: The effective bit count n equals bitCount when bitCount is between 1 and 16; any other value gives 16. resBits reports n.
- R7: resValid is a pulse one system cycle long, in the cycle where csN returns to 1. resData, resBits and nullErr hold their values until the next pulse.
- R8: With freeRun at 0, a startReq sampled while idle begins a frame, with csN low from the next cycle. A startReq during a frame or during the high gap that follows it is ignored. After every frame, csN stays at 1 for at least 2*H cycles.
- R9: With freeRun at 1, frames repeat without startReq. The spacing between frame starts is 2*H*framePeriod cycles when framePeriod is at least 7+n, and 2*H*(7+n) cycles otherwise.
- R10: halfDiv, bitCount and framePeriod are taken at the start of each frame. Changing them during a frame does not alter that frame's timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Single-frame start request |
| freeRun | input | 1 | Repeat frames at the programmed sample period |
| halfDiv | input | 12 | System cycles per data-clock half period |
| bitCount | input | 5 | Number of leading result bits to capture |
| framePeriod | input | 8 | Free-run sample period in data-clock periods |
| sdIn | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Data clock to the converter |
| resValid | output | 1 | One-cycle result strobe |
| resData | output | 16 | Captured word, MSB-aligned, zero-filled |
| resBits | output | 5 | Number of valid bits in resData |
| nullErr | output | 1 | Null bit was sampled high in this frame |

## Verification
The bench drives sdIn high through the sampling window. A controller that reads the window, or that is off by one in its edge count, then shows shifted or corrupted words. Short frames of three bits and out-of-range bit counts check the zero fill and the fallback to 16 bits; a wrong frame length would show up as a wrong csN low time or a wrong rise count. Requests that arrive during a frame or during its gap, and settings changed in the middle of a frame, would add frames or bend the timing if they were not ignored or held. Free-run spacing is measured both above and below the minimum frame, which catches a gap sized from the wrong term.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int STB_W = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} rdState_t;

  typedef struct packed {
    logic             clearWord;
    logic             nullSample;
    logic             bitSample;
    logic [STB_W-1:0] bitIdx;
    logic             finish;
    logic [STB_W-1:0] nBits;
  } rdStrobe_t;
endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LEAD     = 6,
  parameter int DIV_W    = 12,
  parameter int PERIOD_W = 8,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                freeRun,
  input  logic [DIV_W-1:0]    halfDiv,
  input  logic [CNT_W-1:0]    bitCount,
  input  logic [PERIOD_W-1:0] framePeriod,
  output logic                csN,
  output logic                sclk,
  output rdStrobe_t           stb
);
  localparam int RISE_W = $clog2(LEAD + DATA_W + 1);
  localparam int GAP_W  = PERIOD_W + DIV_W + 1;
  localparam logic [RISE_W-1:0] LEAD_R = RISE_W'(LEAD);

  rdState_t              state;
  logic [DIV_W-1:0]      halfLat, halfCnt, halfEff;
  logic [CNT_W-1:0]      nLat, nEff;
  logic [PERIOD_W-1:0]   periodLat, frameLen, gapPer;
  logic                  freeRunLat;
  logic [RISE_W-1:0]     riseCnt, lastRise;
  logic [GAP_W-1:0]      gapCnt, gapLen;
  logic                  gapDone, halfEdge, beginFrame, riseNext;

  // effective settings sampled at frame start
  always_comb begin
    halfEff = (halfDiv == '0) ? DIV_W'(1) : halfDiv;
    if (bitCount == '0 || int'(bitCount) > DATA_W) nEff = CNT_W'(DATA_W);
    else                                           nEff = bitCount;
  end

  // gap after a frame, in system cycles
  always_comb begin
    frameLen = PERIOD_W'(LEAD) + PERIOD_W'(nLat);
    if (freeRunLat && periodLat > frameLen) gapPer = periodLat - frameLen;
    else                                    gapPer = PERIOD_W'(1);
    gapLen  = (GAP_W'(gapPer) * GAP_W'(halfLat)) << 1;
    gapDone = (gapCnt == gapLen - GAP_W'(1));
  end

  assign lastRise   = LEAD_R + RISE_W'(nLat);
  assign halfEdge   = (state == ST_RUN) && (halfCnt == halfLat - DIV_W'(1));
  assign riseNext   = halfEdge && !sclk;
  assign beginFrame = ((state == ST_IDLE) && (startReq || freeRun)) ||
                      ((state == ST_GAP) && gapDone && freeRun);

  always_comb begin
    stb            = '0;
    stb.clearWord  = beginFrame;
    stb.nullSample = riseNext && (riseCnt == LEAD_R - RISE_W'(1));
    stb.bitSample  = riseNext && (riseCnt >= LEAD_R);
    stb.bitIdx     = STB_W'(riseCnt - LEAD_R);
    stb.finish     = halfEdge && sclk && (riseCnt == lastRise);
    stb.nBits      = STB_W'(nLat);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      csN        <= 1'b1;
      sclk       <= 1'b0;
      halfLat    <= DIV_W'(1);
      nLat       <= CNT_W'(DATA_W);
      periodLat  <= '0;
      freeRunLat <= 1'b0;
      halfCnt    <= '0;
      riseCnt    <= '0;
      gapCnt     <= '0;
    end else if (beginFrame) begin
      state      <= ST_RUN;
      csN        <= 1'b0;
      sclk       <= 1'b0;
      halfLat    <= halfEff;
      nLat       <= nEff;
      periodLat  <= framePeriod;
      freeRunLat <= freeRun;
      halfCnt    <= '0;
      riseCnt    <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (halfEdge) begin
            halfCnt <= '0;
            if (!sclk) begin
              sclk    <= 1'b1;
              riseCnt <= riseCnt + RISE_W'(1);
            end else begin
              sclk <= 1'b0;
              if (riseCnt == lastRise) begin
                csN    <= 1'b1;
                state  <= ST_GAP;
                gapCnt <= '0;
              end
            end
          end else begin
            halfCnt <= halfCnt + DIV_W'(1);
          end
        end
        ST_GAP: begin
          if (gapDone) state  <= ST_IDLE;
          else         gapCnt <= gapCnt + GAP_W'(1);
        end
        default: ;
      endcase
    end
  end

  p_clk_parked_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  p_cs_release_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> $fell(sclk));
  p_rise_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    riseCnt <= LEAD_R + RISE_W'(DATA_W));
  p_gap_keeps_cs_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && !gapDone) |=> csN);
endmodule

// File: rtl/adc_rd_dpath.sv
module adc_rd_dpath
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         stb,
  input  logic              sdIn,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [CNT_W-1:0]  resBits,
  output logic              nullErr
);
  logic [DATA_W-1:0] word;
  logic              nullBad;
  int                pos;

  assign pos = DATA_W - 1 - int'(stb.bitIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word     <= '0;
      nullBad  <= 1'b0;
      resValid <= 1'b0;
      resData  <= '0;
      resBits  <= '0;
      nullErr  <= 1'b0;
    end else begin
      resValid <= 1'b0;
      if (stb.clearWord) begin
        word    <= '0;
        nullBad <= 1'b0;
      end
      if (stb.nullSample) nullBad <= sdIn;
      if (stb.bitSample && pos >= 0 && pos < DATA_W) word[pos] <= sdIn;
      if (stb.finish) begin
        resValid <= 1'b1;
        resData  <= word;
        resBits  <= CNT_W'(stb.nBits);
        nullErr  <= nullBad;
      end
    end
  end

  function automatic logic [DATA_W-1:0] lowMask(input int n);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < DATA_W - n);
    return m;
  endfunction

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
  p_result_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> ($stable(resData) && $stable(resBits) && $stable(nullErr)));
  p_bits_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resBits >= CNT_W'(1) && int'(resBits) <= DATA_W));
  p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ((resData & lowMask(int'(resBits))) == '0));
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SAMPLE_CLKS = 5,
  parameter int DIV_W       = 12,
  parameter int PERIOD_W    = 8,
  localparam int CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                freeRun,
  input  logic [DIV_W-1:0]    halfDiv,
  input  logic [CNT_W-1:0]    bitCount,
  input  logic [PERIOD_W-1:0] framePeriod,
  input  logic                sdIn,
  output logic                csN,
  output logic                sclk,
  output logic                resValid,
  output logic [DATA_W-1:0]   resData,
  output logic [CNT_W-1:0]    resBits,
  output logic                nullErr
);
  localparam int LEAD = SAMPLE_CLKS + 1;

  rdStrobe_t stb;

  adc_rd_ctrl #(
    .DATA_W(DATA_W), .LEAD(LEAD), .DIV_W(DIV_W),
    .PERIOD_W(PERIOD_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .halfDiv(halfDiv), .bitCount(bitCount), .framePeriod(framePeriod),
    .csN(csN), .sclk(sclk), .stb(stb)
  );

  adc_rd_dpath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .sdIn(sdIn),
    .resValid(resValid), .resData(resData), .resBits(resBits), .nullErr(nullErr)
  );
endmodule

// File: tb/tb_adc_serial_reader.sv
`timescale 1ns/1ps
module tb_adc_serial_reader;
  localparam int DATA_W = 16;
  localparam int LEAD   = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        freeRun = 1'b0;
  logic [11:0] halfDiv = 12'd1;
  logic [4:0]  bitCount = 5'd16;
  logic [7:0]  framePeriod = 8'd24;
  logic        sdIn = 1'b1;
  logic        csN, sclk, resValid, nullErr;
  logic [15:0] resData;
  logic [4:0]  resBits;

  always #4 clk = ~clk;

  adc_serial_reader dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .halfDiv(halfDiv), .bitCount(bitCount), .framePeriod(framePeriod),
    .sdIn(sdIn), .csN(csN), .sclk(sclk), .resValid(resValid),
    .resData(resData), .resBits(resBits), .nullErr(nullErr)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // expectations set by the test sequence
  int expH = 1, expN = 16, expPeriod = 24;
  bit expFree = 0, injectNull = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model: output changes on falling sclk
  logic [31:0] seed = 32'h1234_5678;
  logic [15:0] curWord;
  int fallCnt = 0;
  logic [15:0] expWordQ[$];
  bit          expNullQ[$];

  always @(negedge csN) begin
    seed    = seed * 32'd1103515245 + 32'd12345;
    curWord = seed[31:16];
    fallCnt = 0;
    sdIn    = 1'b1;
    expWordQ.push_back(curWord & ~(16'hFFFF >> expN));
    expNullQ.push_back(injectNull);
  end

  always @(negedge sclk) begin
    if (!csN) begin
      fallCnt++;
      if (fallCnt < 5)       sdIn = 1'b1;
      else if (fallCnt == 5) sdIn = injectNull;
      else if (fallCnt - 6 < 16) sdIn = curWord[15 - (fallCnt - 6)];
    end
  end

  // cycle monitor / reference
  int  cyc = 0, phaseStart = 0, rises = 0, lastFall = -1, lastRise = -1;
  int  frames = 0, done = 0;
  bit  prevCs = 1'b1, prevSclk = 1'b0;

  function automatic int periodCycles();
    int p;
    p = (expPeriod > LEAD + expN) ? expPeriod : LEAD + expN + 1;
    return 2 * expH * p;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (csN && sclk) check(0, "R2 sclk high while csN high", 1, 0);
      if (prevCs && !csN) begin
        if (lastFall >= 0 && expFree)
          check(cyc - lastFall == periodCycles(), "R9 free-run spacing",
                cyc - lastFall, periodCycles());
        if (lastRise >= 0)
          check(cyc - lastRise >= 2 * expH, "R8 minimum gap", cyc - lastRise, 2 * expH);
        lastFall = cyc; phaseStart = cyc; rises = 0; frames++;
      end else if (!csN && sclk != prevSclk) begin
        if (cyc - phaseStart != expH)
          check(0, "R2 half-phase length", cyc - phaseStart, expH);
        phaseStart = cyc;
        if (sclk) rises++;
      end
      if (!prevCs && csN) begin
        logic [15:0] ew; bit en;
        ew = expWordQ.pop_front(); en = expNullQ.pop_front();
        check(cyc - lastFall == 2 * expH * (LEAD + expN), "R3 csN low time",
              cyc - lastFall, 2 * expH * (LEAD + expN));
        check(rises == LEAD + expN, "R3 rising edge count", rises, LEAD + expN);
        check(resValid == 1'b1, "R7 strobe with csN release", resValid, 1);
        check(resData == ew, "R4 result word", resData, ew);
        check(int'(resBits) == expN, "R6 valid bit count", resBits, expN);
        check(nullErr == en, "R5 null flag", nullErr, en);
        lastRise = cyc; done++;
      end else if (resValid) begin
        check(0, "R7 stray strobe", 1, 0);
      end
      prevCs = csN; prevSclk = sclk;
    end
    cyc++;
  end

  task automatic oneFrame();
    int target;
    target = done + 1;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    wait (done == target);
    repeat (2 * expH + 4) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(csN == 1 && sclk == 0, "R1 csN/sclk at reset", {csN, sclk}, 2);
    check(resValid == 0 && resData == 0 && resBits == 0 && nullErr == 0,
          "R1 result at reset", resData, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R4: full frame at 2.4 MHz-class divider
    halfDiv = 12'd26; bitCount = 5'd16; expH = 26; expN = 16;
    oneFrame();
    // R4 R6: short cycle of three bits, fastest clock
    halfDiv = 12'd1; bitCount = 5'd3; expH = 1; expN = 3;
    oneFrame();
    // R6: zero and oversize counts fall back to 16
    bitCount = 5'd0; expN = 16; oneFrame();
    bitCount = 5'd20; oneFrame();
    // R5: null bit driven high
    halfDiv = 12'd2; expH = 2; bitCount = 5'd9; expN = 9; injectNull = 1;
    oneFrame();
    injectNull = 0;
    oneFrame();
    // R2: divider of zero acts as one
    halfDiv = 12'd0; expH = 1; bitCount = 5'd12; expN = 12;
    oneFrame();

    // R8: start requests during frame and gap are ignored
    begin
      int f0;
      halfDiv = 12'd3; expH = 3; bitCount = 5'd16; expN = 16;
      f0 = frames;
      @(negedge clk) startReq = 1'b1;
      @(negedge clk) startReq = 1'b0;
      repeat (20) @(negedge clk);
      startReq = 1'b1; @(negedge clk) startReq = 1'b0;
      wait (done == f0 + 1);
      @(negedge clk) startReq = 1'b1;
      @(negedge clk) startReq = 1'b0;
      repeat (200) @(negedge clk);
      check(frames == f0 + 1, "R8 extra requests ignored", frames - f0, 1);
    end

    // R10: settings changed mid-frame keep the frame's values
    halfDiv = 12'd2; expH = 2; bitCount = 5'd16; expN = 16;
    begin
      int target;
      target = done + 1;
      @(negedge clk) startReq = 1'b1;
      @(negedge clk) startReq = 1'b0;
      repeat (10) @(negedge clk);
      bitCount = 5'd4; halfDiv = 12'd5;
      wait (done == target);
      repeat (10) @(negedge clk);
      check(1, "R10 mid-frame change held", 0, 0);
    end

    // R9: free run above and below the minimum frame
    halfDiv = 12'd2; expH = 2; bitCount = 5'd16; expN = 16;
    framePeriod = 8'd30; expPeriod = 30; expFree = 1; lastFall = -1;
    begin
      int target;
      target = done + 4;
      @(negedge clk) freeRun = 1'b1;
      wait (done == target);
      @(negedge clk) freeRun = 1'b0;
      repeat (200) @(negedge clk);
    end
    expFree = 0; lastFall = -1;
    framePeriod = 8'd10; expPeriod = 10; bitCount = 5'd8; expN = 8; expFree = 1;
    begin
      int target;
      target = done + 3;
      @(negedge clk) freeRun = 1'b1;
      wait (done == target);
      @(negedge clk) freeRun = 1'b0;
      repeat (200) @(negedge clk);
    end
    expFree = 0;
    check(csN == 1'b1, "R9 free run stops when cleared", csN, 1);
    finish();
  end
endmodule